// File: doc/BRIEF.md
# Scoreboard Hazard Control Unit

This block is the central hazard tracker for a small out-of-order machine with a few functional units. Each instruction moves through four phases: issue, operand read, execution complete and result write. The block keeps one status entry per unit and one pending-writer tag per architectural register. From these it decides when an instruction may enter its unit, when that unit may fetch its operands, and when it may commit its result. Structural, write-after-write, read-after-write and write-after-read conflicts are all settled in this bookkeeping. Data values and arithmetic stay outside the block. Each unit tells the block that it has finished by raising its done line.

Instructions arrive on a valid/ready stream, in program order, one per cycle at most. `iss_ready` depends on the instruction currently offered, so the producer must hold the payload stable while `iss_valid` is high until the cycle in which both lines are high. Back-pressure is total: a refused instruction blocks every instruction behind it. Operand-read grants and write grants are single-cycle pulses and have no handshake.

Top module: `scoreboard_ctrl`

## Requirements
- R1: `iss_ready` is high exactly when the offered unit `iss_unit` holds no instruction and register `iss_dst` has no pending writer. An instruction is accepted in a cycle where `iss_valid` and `iss_ready` are both high.
- R2: While `iss_ready` is low, a held instruction is not accepted and changes no state. It is accepted in the first cycle its conditions clear.
- R3: A unit whose two source registers have no pending writer when it is accepted pulses `rd_grant[i]` for one cycle, in the cycle after acceptance.
- R4: A unit with a source whose writer is still pending gets no read grant before that writer's write grant. It is granted in the cycle after the last such write grant.
- R5: `fu_done[i]` is taken only in cycles after unit i's read grant. A done pulse raised while the unit is idle, waiting to read, or in its read-grant cycle is ignored and produces no write grant.
- R6: A write grant for unit i comes no earlier than the cycle after an accepted done pulse. The unit is idle again in the cycle after its write grant.
- R7: A unit's write is withheld while any other unit has a source equal to this unit's destination and has not yet read it. The write is granted in the cycle after that read grant.
- R8: An instruction whose destination already has a pending writer is refused until the cycle after that writer's write grant.
- R9: At most one bit of `wr_grant` is set per cycle. Among eligible writers, the lowest unit index wins and the others follow in later cycles.
- R10: While `wr_grant` is non-zero, `wr_dst` and `wr_op` carry the destination register and operation code recorded for the granted unit.
- R11: An instruction accepted in the same cycle that its source's producer is granted its write treats that source as ready. Its read grant comes in the next cycle.
- R12: After reset every unit is idle and every register has no pending writer. No grant is raised, and `iss_ready` is high for any offered instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | Instruction offered |
| iss_ready | output | 1 | Offered instruction can be accepted |
| iss_unit | input | $clog2(NUM_FU) | Target functional unit index |
| iss_op | input | OP_W | Operation code, carried through to the write |
| iss_dst | input | $clog2(NUM_REG) | Destination register |
| iss_src1 | input | $clog2(NUM_REG) | First source register |
| iss_src2 | input | $clog2(NUM_REG) | Second source register |
| fu_done | input | NUM_FU | Per-unit execution-finished pulse |
| rd_grant | output | NUM_FU | Per-unit operand-read grant |
| wr_grant | output | NUM_FU | Per-unit result-write grant, one-hot or zero |
| wr_dst | output | $clog2(NUM_REG) | Register written by the granted unit |
| wr_op | output | OP_W | Operation of the granted unit |

## Verification
A cycle-by-cycle script drives a run with no dependences, which separates plain issue and read timing from any stalls. It then adds a write-after-write conflict that must hold the stream back, a read-after-write chain whose read must track the producer's write cycle exactly, and a reader whose pending source forces an earlier writer to wait. Done pulses sent too early show whether premature completion is refused. Two units finishing together expose the priority order. An issue that lands in its producer's write cycle checks the same-cycle forwarding of readiness. A reset in mid-flight confirms that all pending state is dropped.

// File: rtl/sb_pkg.sv
package sb_pkg;
  // Life cycle of one functional-unit entry
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_WAIT  = 2'd1,  // issued, waiting for operands
    PH_EXEC  = 2'd2,  // operands read, unit computing
    PH_WRITE = 2'd3   // result ready, waiting for write grant
  } phase_e;
endpackage

// File: rtl/sb_fu_entry.sv
module sb_fu_entry
  import sb_pkg::*;
#(
  parameter int REG_W = 3,
  parameter int OP_W  = 4,
  parameter int TAG_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue_en,
  input  logic [OP_W-1:0]  new_op,
  input  logic [REG_W-1:0] new_dst,
  input  logic [REG_W-1:0] new_src1,
  input  logic [REG_W-1:0] new_src2,
  input  logic [TAG_W-1:0] new_q1,
  input  logic [TAG_W-1:0] new_q2,
  input  logic             done_in,
  input  logic             wb_valid,
  input  logic [TAG_W-1:0] wb_tag,
  input  logic             wr_win,
  output logic             busy,
  output logic [OP_W-1:0]  op,
  output logic [REG_W-1:0] fi,
  output logic [REG_W-1:0] fj,
  output logic [REG_W-1:0] fk,
  output logic             rj,
  output logic             rk,
  output logic             rd_grant,
  output logic             exec_fin
);
  phase_e           phase;
  logic [TAG_W-1:0] qj, qk;

  assign busy     = (phase != PH_IDLE);
  assign rd_grant = (phase == PH_WAIT) && rj && rk;
  assign exec_fin = (phase == PH_WRITE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      op <= '0; fi <= '0; fj <= '0; fk <= '0;
      qj <= '0; qk <= '0; rj <= 1'b0; rk <= 1'b0;
    end else begin
      unique case (phase)
        PH_IDLE:  if (issue_en) phase <= PH_WAIT;
        PH_WAIT:  if (rd_grant) phase <= PH_EXEC;
        PH_EXEC:  if (done_in)  phase <= PH_WRITE;
        PH_WRITE: if (wr_win)   phase <= PH_IDLE;
      endcase
      if (issue_en) begin
        op <= new_op; fi <= new_dst; fj <= new_src1; fk <= new_src2;
        qj <= new_q1; qk <= new_q2;
        rj <= (new_q1 == '0);
        rk <= (new_q2 == '0);
      end else if (rd_grant) begin
        rj <= 1'b0;
        rk <= 1'b0;
      end else begin
        if (wb_valid && qj != '0 && qj == wb_tag) begin
          rj <= 1'b1;
          qj <= '0;
        end
        if (wb_valid && qk != '0 && qk == wb_tag) begin
          rk <= 1'b1;
          qk <= '0;
        end
      end
    end
  end

  // R1: a unit is only loaded while it is free
  p_issue_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    issue_en |-> phase == PH_IDLE);
  // R3: reading operands consumes both ready flags
  p_read_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_grant |=> (!rj && !rk));
  // R5: no completion can be recorded before the operands were read
  p_no_early_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_WAIT) |=> (phase != PH_WRITE));
endmodule

// File: rtl/sb_result_status.sv
module sb_result_status #(
  parameter int NUM_REG = 8,
  parameter int REG_W   = 3,
  parameter int TAG_W   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic [REG_W-1:0] set_reg,
  input  logic [TAG_W-1:0] set_tag,
  input  logic             clr_en,
  input  logic [REG_W-1:0] clr_reg,
  input  logic [REG_W-1:0] look_dst,
  input  logic [REG_W-1:0] look_s1,
  input  logic [REG_W-1:0] look_s2,
  output logic [TAG_W-1:0] dst_tag,
  output logic [TAG_W-1:0] s1_tag,
  output logic [TAG_W-1:0] s2_tag
);
  logic [TAG_W-1:0] writer [NUM_REG];

  assign dst_tag = writer[look_dst];
  assign s1_tag  = writer[look_s1];
  assign s2_tag  = writer[look_s2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < NUM_REG; r++) writer[r] <= '0;
    end else begin
      if (clr_en) writer[clr_reg] <= '0;
      if (set_en) writer[set_reg] <= set_tag;
    end
  end

  // R8: an accepted instruction becomes the pending writer of its destination
  p_status_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> writer[$past(set_reg)] == $past(set_tag));
endmodule

// File: rtl/sb_write_arb.sv
module sb_write_arb #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  output logic [N-1:0] grant
);
  always_comb begin
    grant = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) grant = N'(1) << i;
    end
  end

  // R9: a single writer per cycle, and only a requester
  p_single_writer_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  p_grant_has_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~req) == '0);
endmodule

// File: rtl/scoreboard_ctrl.sv
module scoreboard_ctrl #(
  parameter int NUM_FU  = 4,
  parameter int NUM_REG = 8,
  parameter int OP_W    = 4,
  localparam int FU_W   = $clog2(NUM_FU),
  localparam int REG_W  = $clog2(NUM_REG),
  localparam int TAG_W  = $clog2(NUM_FU + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              iss_valid,
  output logic              iss_ready,
  input  logic [FU_W-1:0]   iss_unit,
  input  logic [OP_W-1:0]   iss_op,
  input  logic [REG_W-1:0]  iss_dst,
  input  logic [REG_W-1:0]  iss_src1,
  input  logic [REG_W-1:0]  iss_src2,
  input  logic [NUM_FU-1:0] fu_done,
  output logic [NUM_FU-1:0] rd_grant,
  output logic [NUM_FU-1:0] wr_grant,
  output logic [REG_W-1:0]  wr_dst,
  output logic [OP_W-1:0]   wr_op
);
  // Tag 0 = no pending writer; unit i is tag i+1
  logic [NUM_FU-1:0] fu_busy, exec_fin, war_block, issue_en;
  logic [OP_W-1:0]   e_op [NUM_FU];
  logic [REG_W-1:0]  e_fi [NUM_FU];
  logic [REG_W-1:0]  e_fj [NUM_FU];
  logic [REG_W-1:0]  e_fk [NUM_FU];
  logic [NUM_FU-1:0] e_rj, e_rk;

  logic [TAG_W-1:0]  dst_tag, raw_q1, raw_q2, q1, q2, wb_tag, my_tag;
  logic [FU_W-1:0]   wb_idx;
  logic              wb_valid, issue_fire, unit_free;

  // Writer selection
  always_comb begin
    wb_idx = '0;
    for (int i = 0; i < NUM_FU; i++) begin
      if (wr_grant[i]) wb_idx = FU_W'(i);
    end
  end
  assign wb_valid = |wr_grant;
  assign wb_tag   = TAG_W'(wb_idx) + TAG_W'(1);
  assign wr_dst   = wb_valid ? e_fi[wb_idx] : '0;
  assign wr_op    = wb_valid ? e_op[wb_idx] : '0;

  // Issue decision
  assign unit_free  = (int'(iss_unit) < NUM_FU) && !fu_busy[iss_unit];
  assign iss_ready  = unit_free && (dst_tag == '0);
  assign issue_fire = iss_valid && iss_ready;
  assign my_tag     = TAG_W'(iss_unit) + TAG_W'(1);
  // A producer writing this very cycle no longer counts as pending
  assign q1 = (wb_valid && raw_q1 == wb_tag) ? '0 : raw_q1;
  assign q2 = (wb_valid && raw_q2 == wb_tag) ? '0 : raw_q2;

  // Write-after-read guard: hold a write while another unit still needs the old value
  always_comb begin
    for (int i = 0; i < NUM_FU; i++) begin
      war_block[i] = 1'b0;
      for (int j = 0; j < NUM_FU; j++) begin
        if (j != i && ((e_fj[j] == e_fi[i] && e_rj[j]) ||
                       (e_fk[j] == e_fi[i] && e_rk[j])))
          war_block[i] = 1'b1;
      end
    end
  end

  sb_result_status #(.NUM_REG(NUM_REG), .REG_W(REG_W), .TAG_W(TAG_W)) u_status (
    .clk(clk), .rst_n(rst_n),
    .set_en(issue_fire), .set_reg(iss_dst), .set_tag(my_tag),
    .clr_en(wb_valid), .clr_reg(wr_dst),
    .look_dst(iss_dst), .look_s1(iss_src1), .look_s2(iss_src2),
    .dst_tag(dst_tag), .s1_tag(raw_q1), .s2_tag(raw_q2)
  );

  sb_write_arb #(.N(NUM_FU)) u_arb (
    .clk(clk), .rst_n(rst_n),
    .req(exec_fin & ~war_block), .grant(wr_grant)
  );

  for (genvar g = 0; g < NUM_FU; g++) begin : g_unit
    assign issue_en[g] = issue_fire && (int'(iss_unit) == g);

    sb_fu_entry #(.REG_W(REG_W), .OP_W(OP_W), .TAG_W(TAG_W)) u_entry (
      .clk(clk), .rst_n(rst_n),
      .issue_en(issue_en[g]), .new_op(iss_op), .new_dst(iss_dst),
      .new_src1(iss_src1), .new_src2(iss_src2), .new_q1(q1), .new_q2(q2),
      .done_in(fu_done[g]), .wb_valid(wb_valid), .wb_tag(wb_tag),
      .wr_win(wr_grant[g]),
      .busy(fu_busy[g]), .op(e_op[g]), .fi(e_fi[g]), .fj(e_fj[g]), .fk(e_fk[g]),
      .rj(e_rj[g]), .rk(e_rk[g]), .rd_grant(rd_grant[g]), .exec_fin(exec_fin[g])
    );

    // R6: a granted write frees its unit on the next cycle
    p_grant_frees_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_grant[g] |=> !fu_busy[g]);
  end
endmodule

// File: tb/scoreboard_ctrl_test.sv
module scoreboard_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       iss_valid = 1'b0;
  logic       iss_ready;
  logic [1:0] iss_unit = '0;
  logic [3:0] iss_op = '0;
  logic [2:0] iss_dst = '0, iss_src1 = '0, iss_src2 = '0;
  logic [3:0] fu_done = '0;
  logic [3:0] rd_grant, wr_grant;
  logic [2:0] wr_dst;
  logic [3:0] wr_op;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;  // 125 MHz

  scoreboard_ctrl #(.NUM_FU(4), .NUM_REG(8), .OP_W(4)) uut (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_ready(iss_ready),
    .iss_unit(iss_unit), .iss_op(iss_op), .iss_dst(iss_dst),
    .iss_src1(iss_src1), .iss_src2(iss_src2), .fu_done(fu_done),
    .rd_grant(rd_grant), .wr_grant(wr_grant), .wr_dst(wr_dst), .wr_op(wr_op)
  );

  typedef struct packed {
    logic       v;
    logic [1:0] u;
    logic [3:0] op;
    logic [2:0] dst;
    logic [2:0] s1;
    logic [2:0] s2;
    logic [3:0] done;
    logic       rdy;
    logic [3:0] rd;
    logic [3:0] wr;
    logic [2:0] wdst;
    logic [3:0] wop;
    logic [3:0] req;
  } step_t;

  // v u op dst s1 s2 done | rdy rd wr wdst wop | requirement
  localparam int NSTEP = 38;
  localparam step_t STEPS [NSTEP] = '{
    '{1'b1,2'd0,4'd1, 3'd1,3'd2,3'd3,4'b0000, 1'b1,4'b0000,4'b0000,3'd0,4'd0, 4'd1},  // 0 R1
    '{1'b1,2'd1,4'd2, 3'd4,3'd1,3'd5,4'b0000, 1'b1,4'b0001,4'b0000,3'd0,4'd0, 4'd3},  // 1 R3
    '{1'b1,2'd2,4'd3, 3'd1,3'd6,3'd7,4'b0000, 1'b0,4'b0000,4'b0000,3'd0,4'd0, 4'd8},  // 2 R8
    '{1'b1,2'd2,4'd3, 3'd1,3'd6,3'd7,4'b0001, 1'b0,4'b0000,4'b0000,3'd0,4'd0, 4'd2},  // 3 R2
    '{1'b1,2'd2,4'd3, 3'd1,3'd6,3'd7,4'b0000, 1'b0,4'b0000,4'b0001,3'd1,4'd1, 4'd10}, // 4 R10
    '{1'b1,2'd2,4'd3, 3'd1,3'd6,3'd7,4'b0000, 1'b1,4'b0010,4'b0000,3'd0,4'd0, 4'd4},  // 5 R4
    '{1'b0,2'd0,4'd0, 3'd0,3'd0,3'd0,4'b0010, 1'b1,4'b0100,4'b0000,3'd0,4'd0, 4'd3},  // 6 R3
    '{1'b0,2'd0,4'd0, 3'd0,3'd0,3'd0,4'b0100, 1'b1,4'b0000,4'b0010,3'd4,4'd2, 4'd6},  // 7 R6
    '{1'b0,2'd0,4'd0, 3'd0,3'd0,3'd0,4'b0000, 1'b1,4'b0000,4'b0100,3'd1,4'd3, 4'd6},  // 8 R6
    '{1'b1,2'd1,4'd4, 3'd2,3'd0,3'd0,4'b0000, 1'b1,4'b0000,4'b0000,3'd0,4'd0, 4'd1},  // 9 R1
    '{1'b1,2'd3,4'd5, 3'd3,3'd5,3'd2,4'b0000, 1'b1,4'b0010,4'b0000,3'd0,4'd0, 4'd3},  // 10 R3
    '{1'b1,2'd0,4'd6, 3'd5,3'd0,3'd0,4'b0000, 1'b1,4'b0000,4'b0000,3'd0,4'd0, 4'd4},  // 11 R4
    '{1'b0,2'd0,4'd0, 3'd0,3'd0,3'd0,4'b0000, 1'b0,4'b0001,4'b0000,3'd0,4'd0, 4'd3},  // 12 R3
    '{1'b0,2'd0,4'd0, 3'd0,3'd0,3'd0,4'b0001, 1'b0,4'b0000,4'b0000,3'd0,4'd0, 4'd1},  // 13 R1
    '{1'b0,2'd0,4'd0, 3'd0,3'd0,3'd0,4'b0010, 1'b0,4'b0000,4'b0000,3'd0,4'd0, 4'd7},  // 14 R7
    '{1'b0,2'd0,4'd0, 3'd0,3'd0,3'd0,4'b0000, 1'b0,4'b0000,4'b0010,3'd2,4'd4, 4'd7},  // 15 R7
    '{1'b0,2'd0,4'd0, 3'd0,3'd0,3'd0,4'b0000, 1'b0,4'b1000,4'b0000,3'd0,4'd0, 4'd4},  // 16 R4
    '{1'b0,2'd0,4'd0, 3'd0,3'd0,3'd0,4'b1000, 1'b0,4'b0000,4'b0001,3'd5,4'd6, 4'd7},  // 17 R7
    '{1'b0,2'd0,4'd0, 3'd0,3'd0,3'd0,4'b0000, 1'b1,4'b0000,4'b1000,3'd3,4'd5, 4'd6},  // 18 R6
    '{1'b1,2'd0,4'd7, 3'd6,3'd1,3'd1,4'b0001, 1'b1,4'b0000,4'b0000,3'd0,4'd0, 4'd5},  // 19 R5
    '{1'b0,2'd0,4'd0, 3'd0,3'd0,3'd0,4'b0001, 1'b0,4'b0001,4'b0000,3'd0,4'd0, 4'd5},  // 20 R5
    '{1'b0,2'd0,4'd0, 3'd0,3'd0,3'd0,4'b0000, 1'b0,4'b0000,4'b0000,3'd0,4'd0, 4'd5},  // 21 R5
    '{1'b0,2'd0,4'd0, 3'd0,3'd0,3'd0,4'b0001, 1'b0,4'b0000,4'b0000,3'd0,4'd0, 4'd5},  // 22 R5
    '{1'b0,2'd0,4'd0, 3'd0,3'd0,3'd0,4'b0000, 1'b0,4'b0000,4'b0001,3'd6,4'd7, 4'd6},  // 23 R6
    '{1'b1,2'd2,4'd8, 3'd0,3'd1,3'd1,4'b0000, 1'b1,4'b0000,4'b0000,3'd0,4'd0, 4'd1},  // 24 R1
    '{1'b1,2'd1,4'd9, 3'd7,3'd1,3'd1,4'b0000, 1'b1,4'b0100,4'b0000,3'd0,4'd0, 4'd3},  // 25 R3
    '{1'b0,2'd0,4'd0, 3'd0,3'd0,3'd0,4'b0000, 1'b0,4'b0010,4'b0000,3'd0,4'd0, 4'd8},  // 26 R8
    '{1'b0,2'd0,4'd0, 3'd0,3'd0,3'd0,4'b0110, 1'b0,4'b0000,4'b0000,3'd0,4'd0, 4'd8},  // 27 R8
    '{1'b0,2'd0,4'd0, 3'd0,3'd0,3'd0,4'b0000, 1'b0,4'b0000,4'b0010,3'd7,4'd9, 4'd9},  // 28 R9
    '{1'b0,2'd0,4'd0, 3'd0,3'd0,3'd0,4'b0000, 1'b0,4'b0000,4'b0100,3'd0,4'd8, 4'd9},  // 29 R9
    '{1'b1,2'd0,4'd10,3'd3,3'd4,3'd4,4'b0000, 1'b1,4'b0000,4'b0000,3'd0,4'd0, 4'd8},  // 30 R8
    '{1'b1,2'd1,4'd11,3'd5,3'd3,3'd3,4'b0000, 1'b1,4'b0001,4'b0000,3'd0,4'd0, 4'd4},  // 31 R4
    '{1'b0,2'd0,4'd0, 3'd0,3'd0,3'd0,4'b0001, 1'b0,4'b0000,4'b0000,3'd0,4'd0, 4'd4},  // 32 R4
    '{1'b1,2'd2,4'd12,3'd2,3'd3,3'd3,4'b0000, 1'b1,4'b0000,4'b0001,3'd3,4'd10,4'd11}, // 33 R11
    '{1'b0,2'd0,4'd0, 3'd0,3'd0,3'd0,4'b0000, 1'b1,4'b0110,4'b0000,3'd0,4'd0, 4'd11}, // 34 R11
    '{1'b0,2'd0,4'd0, 3'd0,3'd0,3'd0,4'b0110, 1'b1,4'b0000,4'b0000,3'd0,4'd0, 4'd9},  // 35 R9
    '{1'b0,2'd0,4'd0, 3'd0,3'd0,3'd0,4'b0000, 1'b1,4'b0000,4'b0010,3'd5,4'd11,4'd9},  // 36 R9
    '{1'b0,2'd0,4'd0, 3'd0,3'd0,3'd0,4'b0000, 1'b1,4'b0000,4'b0100,3'd2,4'd12,4'd10}  // 37 R10
  };

  task automatic chk(input int req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL R%0d %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #800000;
    errors++;
    checks++;
    $display("FAIL R12 watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    // R12: reset state
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(12, "ready after reset", int'(iss_ready), 1);
    chk(12, "rd_grant after reset", int'(rd_grant), 0);
    chk(12, "wr_grant after reset", int'(wr_grant), 0);

    // Scripted cycle table
    for (int k = 0; k < NSTEP; k++) begin
      @(negedge clk);
      iss_valid = STEPS[k].v;
      iss_unit  = STEPS[k].u;
      iss_op    = STEPS[k].op;
      iss_dst   = STEPS[k].dst;
      iss_src1  = STEPS[k].s1;
      iss_src2  = STEPS[k].s2;
      fu_done   = STEPS[k].done;
      #1;
      chk(int'(STEPS[k].req), $sformatf("step %0d iss_ready", k), int'(iss_ready), int'(STEPS[k].rdy));
      chk(int'(STEPS[k].req), $sformatf("step %0d rd_grant", k), int'(rd_grant), int'(STEPS[k].rd));
      chk(int'(STEPS[k].req), $sformatf("step %0d wr_grant", k), int'(wr_grant), int'(STEPS[k].wr));
      if (STEPS[k].wr != 4'b0000) begin
        chk(10, $sformatf("step %0d wr_dst", k), int'(wr_dst), int'(STEPS[k].wdst));
        chk(10, $sformatf("step %0d wr_op", k), int'(wr_op), int'(STEPS[k].wop));
      end
    end

    // Directed: reset in mid-flight drops pending state (R12)
    @(negedge clk);
    iss_valid = 1'b1; iss_unit = 2'd3; iss_op = 4'd13;
    iss_dst = 3'd4; iss_src1 = 3'd0; iss_src2 = 3'd0; fu_done = '0;
    @(negedge clk);
    iss_valid = 1'b0;
    #1;
    chk(3, "mid-flight read grant", int'(rd_grant), 4'b1000);
    chk(1, "unit 3 busy refuses issue", int'(iss_ready), 0);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(12, "ready for unit 3 after reset", int'(iss_ready), 1);
    chk(12, "no read grant after reset", int'(rd_grant), 0);
    chk(12, "no write grant after reset", int'(wr_grant), 0);
    @(negedge clk);
    fu_done = 4'b1000;
    @(negedge clk);
    fu_done = '0;
    #1;
    chk(5, "done on reset unit ignored", int'(wr_grant), 0);

    finish_run();
  end
endmodule